// File: doc/BRIEF.md
# Flash Embedded Operation Sequencer

This block is the self-timed controller that sits in front of a small register-based model of a sector-erasable flash array. It receives commands that are already decoded: byte program, erase of a set of sectors, erase suspend and erase resume. Each command comes with an address, a data byte and a sector selection mask. The block then runs the whole operation without further help. A byte program is a loop of timed pulses and verify steps. An erase runs three phases. First it programs every remaining 1 bit of each selected sector to 0. Then it applies timed erase pulses. Each pulse is followed by a verify of the whole sector, and the pulses repeat until every byte reads 8'hFF.

While an operation is running, the ready/busy output is low. A read returns a status byte instead of array data. Bit 7 of the status byte is the complement of the target data bit, and bit 6 changes on every status read. A suspended erase frees the array so that the host can read and program sectors outside the erase selection. A resume picks the erase up at exactly the point where it stopped. Groups of four adjacent sectors can be write-protected. A synchronous hardware abort input returns the block to read mode, and a low-supply input blocks new writes.

The default geometry is 32 sectors of 4 bytes. This keeps the array small enough to hold in registers, while the sector number still comes from the top address bits.

Top module: `flash_op_seq`

## Requirements
- R1: After `rst_n` is released, `ry_by` is 1 and every array byte reads 8'hFF.
- R2: A program command (`cmd_op`=1) leaves the byte at `cmd_addr` equal to old AND `cmd_data`. The block is busy for exactly 1 + k*(PGM_PULSE+1) cycles, where k is the number of bits set in (old AND NOT `cmd_data`).
- R3: An erase command (`cmd_op`=2) sets every byte of each selected sector to 8'hFF. Each sector costs SECT_BYTES + P*(PGM_PULSE+1) + 1 + 8*(ERS_PULSE+1) busy cycles, where P is the number of 1 bits the sector holds when the command starts. The preprogram phase brings the sector to all zeros, so the erase phase always takes eight pulses.
- R4: One erase command handles every sector set in `cmd_sect_mask`, and it leaves sectors that are not selected unchanged. An all-zero mask is ignored.
- R5: Sector s belongs to protection group s/4 and is protected when `protect[s/4]` is 1. A program aimed at a protected sector, or an erase whose mask holds only protected sectors, keeps the block busy for PROT_CYC cycles and changes nothing. Protected sectors in a mixed mask are skipped.
- R6: A read that the block accepts while it is busy returns {~t, g, 6'b0}. Here t is `cmd_data[7]` for a program and 1 for an erase, and g starts at 0 after reset and inverts on every status read. Reads return data one cycle after `rd_en`.
- R7: When the block is idle or suspended, `ry_by` is 1 and reads return array data. The block goes back to this state by itself when an operation completes.
- R8: A suspend (`cmd_op`=3) during the erase phases raises `ry_by` on the next cycle and freezes the erase. A resume (`cmd_op`=4) continues the erase, and the busy cycles after the resume equal those that were left at the suspend.
- R9: While an erase is suspended, a program to a sector outside the erase selection runs and then returns to the suspended state. A program to a selected sector is ignored, and so is an erase command.
- R10: Driving `hw_rst_n` low aborts any operation, and `ry_by` is 1 on the next cycle. Bytes that the operation had not reached keep their values.
- R11: While `low_vcc` is 1, program and erase commands are ignored.
- R12: While a program runs, every other command is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; array becomes all 8'hFF |
| hw_rst_n | input | 1 | Synchronous active-low operation abort; array kept |
| low_vcc | input | 1 | Supply-low flag, blocks program and erase commands |
| protect | input | 8 | Protection bit per group of four sectors |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | 1 program, 2 erase, 3 suspend, 4 resume |
| cmd_addr | input | 7 | Byte address for a program; upper 5 bits give the sector |
| cmd_data | input | 8 | Program data |
| cmd_sect_mask | input | 32 | Sectors selected by an erase |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 7 | Read address |
| rd_data | output | 8 | Array data or status, registered |
| ry_by | output | 1 | 1 when ready, 0 while an operation runs |

## Verification
The bench goes after exact cycle counts. A design that skips already-programmed bytes in the wrong way during preprogram, or that adds or drops one verify step, finishes on a different cycle than the model expects, and the `ry_by` comparison catches it. It suspends an erase in the middle, programs around it, and tries a program into the selected sector. A design that let that program through, or that lost its pulse position across the suspend, shows up as a wrong byte or a wrong finish time. Protected groups are hit by a direct program, by an erase of only protected sectors, and by a mixed mask, so a design that erased a protected sector fails the readback. Status reads are issued back to back to catch a toggle bit that sticks, and an abort in the middle of an erase checks that a neighbouring sector is left alone.

// File: rtl/fos_pkg.sv
package fos_pkg;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_PROG   = 3'd1,
    OP_ERASE  = 3'd2,
    OP_SUSP   = 3'd3,
    OP_RESUME = 3'd4
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PGM_VFY,
    S_PGM_PULSE,
    S_PRE_VFY,
    S_PRE_PULSE,
    S_ERS_VFY,
    S_ERS_PULSE,
    S_PROT_WAIT,
    S_SUSP
  } st_e;

endpackage

// File: rtl/fos_cell_array.sv
module fos_cell_array #(
  parameter int N_SECT     = 32,
  parameter int SECT_BYTES = 4,
  localparam int NB = N_SECT * SECT_BYTES,
  localparam int AW = $clog2(NB),
  localparam int SW = $clog2(N_SECT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pgm_stb,
  input  logic [AW-1:0] pgm_addr,
  input  logic [7:0]    pgm_mask,
  input  logic          ers_stb,
  input  logic [SW-1:0] ers_sect,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_byte,
  input  logic [AW-1:0] vfy_addr,
  output logic [7:0]    vfy_byte,
  output logic          sect_ff
);

  logic [7:0] mem   [NB];
  logic [7:0] mem_d [NB];
  logic [7:0] clr;

  // one program pulse clears the lowest cell still to be cleared;
  // one erase pulse sets the lowest cleared cell of every byte in the sector
  always_comb begin
    for (int i = 0; i < NB; i++) mem_d[i] = mem[i];
    clr = mem[pgm_addr] & pgm_mask;
    if (pgm_stb) mem_d[pgm_addr] = mem[pgm_addr] & ~(clr & (~clr + 8'd1));
    if (ers_stb) begin
      for (int b = 0; b < SECT_BYTES; b++) begin
        mem_d[int'(ers_sect) * SECT_BYTES + b] =
          mem[int'(ers_sect) * SECT_BYTES + b] | (mem[int'(ers_sect) * SECT_BYTES + b] + 8'd1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) mem[i] <= 8'hFF;
    end else begin
      for (int i = 0; i < NB; i++) mem[i] <= mem_d[i];
    end
  end

  always_comb begin
    sect_ff = 1'b1;
    for (int b = 0; b < SECT_BYTES; b++)
      if (mem[int'(ers_sect) * SECT_BYTES + b] != 8'hFF) sect_ff = 1'b0;
  end

  assign rd_byte  = mem[rd_addr];
  assign vfy_byte = mem[vfy_addr];

  AST_PGM_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_stb |=> ($countones(mem[$past(pgm_addr)]) + 1 == $countones($past(mem[pgm_addr])))); // R2

  AST_NO_DUAL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !(pgm_stb && ers_stb)); // R3

endmodule

// File: rtl/fos_status.sv
module fos_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_en,
  input  logic       busy,
  input  logic       tgt7,
  input  logic [7:0] arr_byte,
  output logic [7:0] rd_data
);

  logic       tog, tog_d;
  logic [7:0] rd_d;

  always_comb begin
    tog_d = tog;
    rd_d  = rd_data;
    if (rd_en) begin
      if (busy) begin
        rd_d  = {~tgt7, tog, 6'b0};
        tog_d = ~tog;
      end else begin
        rd_d  = arr_byte;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog     <= 1'b0;
      rd_data <= 8'h00;
    end else begin
      if (rd_en) begin
        tog     <= tog_d;
        rd_data <= rd_d;
      end
    end
  end

  AST_TOG_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy) |=> (rd_data[6] != tog)); // R6

endmodule

// File: rtl/flash_op_seq.sv
module flash_op_seq #(
  parameter int N_SECT     = 32,
  parameter int SECT_BYTES = 4,
  parameter int GRP_SECT   = 4,
  parameter int PGM_PULSE  = 3,
  parameter int ERS_PULSE  = 5,
  parameter int PROT_CYC   = 4,
  localparam int NB    = N_SECT * SECT_BYTES,
  localparam int AW    = $clog2(NB),
  localparam int SW    = $clog2(N_SECT),
  localparam int BW    = $clog2(SECT_BYTES),
  localparam int N_GRP = N_SECT / GRP_SECT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_rst_n,
  input  logic              low_vcc,
  input  logic [N_GRP-1:0]  protect,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [AW-1:0]     cmd_addr,
  input  logic [7:0]        cmd_data,
  input  logic [N_SECT-1:0] cmd_sect_mask,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [7:0]        rd_data,
  output logic              ry_by
);
  import fos_pkg::*;

  localparam int CMAX = (PGM_PULSE > ERS_PULSE) ?
                        ((PGM_PULSE > PROT_CYC) ? PGM_PULSE : PROT_CYC) :
                        ((ERS_PULSE > PROT_CYC) ? ERS_PULSE : PROT_CYC);
  localparam int CW = $clog2(CMAX) + 1;

  st_e             st, st_d, sv_st;
  logic [CW-1:0]   cnt, cnt_d, sv_cnt;
  logic            sv_en;
  logic            from_susp, from_susp_d;
  logic [AW-1:0]   pgm_addr_q;
  logic [7:0]      pgm_mask_q;
  logic            tgt7_q, tgt7_d, ld_pgm, ld_tgt;
  logic [N_SECT-1:0] ers_sel, ers_sel_d;
  logic            ld_sel;
  logic [SW-1:0]   ers_sect, ers_sect_d;
  logic [BW-1:0]   ers_byte, ers_byte_d;
  logic            pos_we;

  op_e             op;
  logic            start_ok, busy, in_ers, vfy_pass;
  logic [SW-1:0]   cmd_sect;
  logic [N_SECT-1:0] prot_sect, ers_eff;
  logic [SW:0]     first_pick, next_pick;

  logic            arr_pgm_stb, arr_ers_stb, sect_ff;
  logic [AW-1:0]   arr_addr;
  logic [7:0]      arr_mask, vfy_byte, rd_byte;

  function automatic logic [SW:0] pick_low(input logic [N_SECT-1:0] m, input int lo);
    logic [SW:0] r;
    r = '0;
    for (int s = N_SECT - 1; s >= 0; s--)
      if (m[s] && (s >= lo)) r = {1'b1, SW'(s)};
    return r;
  endfunction

  for (genvar g = 0; g < N_SECT; g++) begin : g_prot
    assign prot_sect[g] = protect[g / GRP_SECT];
  end

  assign op         = op_e'(cmd_op);
  assign start_ok   = cmd_valid && !low_vcc;
  assign cmd_sect   = cmd_addr[AW-1:BW];
  assign ers_eff    = cmd_sect_mask & ~prot_sect;
  assign first_pick = pick_low(ers_eff, 0);
  assign next_pick  = pick_low(ers_sel, int'(ers_sect) + 1);

  assign in_ers   = (st == S_PRE_VFY) || (st == S_PRE_PULSE) ||
                    (st == S_ERS_VFY) || (st == S_ERS_PULSE);
  assign busy     = (st != S_IDLE) && (st != S_SUSP);
  assign ry_by    = !busy;
  assign arr_addr = in_ers ? {ers_sect, ers_byte} : pgm_addr_q;
  assign arr_mask = in_ers ? 8'hFF : pgm_mask_q;
  assign vfy_pass = (vfy_byte & arr_mask) == 8'h00;

  // next-state process
  always_comb begin
    st_d        = st;
    cnt_d       = cnt;
    from_susp_d = from_susp;
    sv_en       = 1'b0;
    ld_pgm      = 1'b0;
    ld_tgt      = 1'b0;
    tgt7_d      = tgt7_q;
    ld_sel      = 1'b0;
    ers_sel_d   = ers_sel;
    pos_we      = 1'b0;
    ers_sect_d  = ers_sect;
    ers_byte_d  = ers_byte;
    arr_pgm_stb = 1'b0;
    arr_ers_stb = 1'b0;

    case (st)
      S_IDLE: begin
        if (start_ok && op == OP_PROG) begin
          ld_pgm      = 1'b1;
          ld_tgt      = 1'b1;
          tgt7_d      = cmd_data[7];
          from_susp_d = 1'b0;
          cnt_d       = '0;
          st_d        = prot_sect[cmd_sect] ? S_PROT_WAIT : S_PGM_VFY;
        end else if (start_ok && op == OP_ERASE && (|cmd_sect_mask)) begin
          ld_tgt      = 1'b1;
          tgt7_d      = 1'b1;
          from_susp_d = 1'b0;
          cnt_d       = '0;
          if (first_pick[SW]) begin
            ld_sel     = 1'b1;
            ers_sel_d  = ers_eff;
            pos_we     = 1'b1;
            ers_sect_d = first_pick[SW-1:0];
            ers_byte_d = '0;
            st_d       = S_PRE_VFY;
          end else begin
            st_d = S_PROT_WAIT;
          end
        end
      end
      S_PGM_VFY: begin
        if (vfy_pass) begin
          st_d = from_susp ? S_SUSP : S_IDLE;
        end else begin
          cnt_d = '0;
          st_d  = S_PGM_PULSE;
        end
      end
      S_PGM_PULSE: begin
        if (cnt == CW'(PGM_PULSE - 1)) begin
          arr_pgm_stb = 1'b1;
          st_d        = S_PGM_VFY;
        end else begin
          cnt_d = cnt + 1'b1;
        end
      end
      S_PROT_WAIT: begin
        if (cnt == CW'(PROT_CYC - 1)) st_d = from_susp ? S_SUSP : S_IDLE;
        else                          cnt_d = cnt + 1'b1;
      end
      S_PRE_VFY, S_PRE_PULSE, S_ERS_VFY, S_ERS_PULSE: begin
        if (cmd_valid && op == OP_SUSP) begin
          sv_en = 1'b1;
          st_d  = S_SUSP;
        end else begin
          case (st)
            S_PRE_VFY: begin
              if (!vfy_pass) begin
                cnt_d = '0;
                st_d  = S_PRE_PULSE;
              end else if (ers_byte == BW'(SECT_BYTES - 1)) begin
                st_d = S_ERS_VFY;
              end else begin
                pos_we     = 1'b1;
                ers_byte_d = ers_byte + 1'b1;
              end
            end
            S_PRE_PULSE: begin
              if (cnt == CW'(PGM_PULSE - 1)) begin
                arr_pgm_stb = 1'b1;
                st_d        = S_PRE_VFY;
              end else begin
                cnt_d = cnt + 1'b1;
              end
            end
            S_ERS_VFY: begin
              if (!sect_ff) begin
                cnt_d = '0;
                st_d  = S_ERS_PULSE;
              end else if (next_pick[SW]) begin
                pos_we     = 1'b1;
                ers_sect_d = next_pick[SW-1:0];
                ers_byte_d = '0;
                st_d       = S_PRE_VFY;
              end else begin
                st_d = S_IDLE;
              end
            end
            default: begin
              if (cnt == CW'(ERS_PULSE - 1)) begin
                arr_ers_stb = 1'b1;
                st_d        = S_ERS_VFY;
              end else begin
                cnt_d = cnt + 1'b1;
              end
            end
          endcase
        end
      end
      S_SUSP: begin
        if (cmd_valid && op == OP_RESUME) begin
          st_d  = sv_st;
          cnt_d = sv_cnt;
        end else if (start_ok && op == OP_PROG && !ers_sel[cmd_sect]) begin
          ld_pgm      = 1'b1;
          ld_tgt      = 1'b1;
          tgt7_d      = cmd_data[7];
          from_susp_d = 1'b1;
          cnt_d       = '0;
          st_d        = prot_sect[cmd_sect] ? S_PROT_WAIT : S_PGM_VFY;
        end
      end
      default: st_d = S_IDLE;
    endcase

    if (!hw_rst_n) begin
      st_d        = S_IDLE;
      from_susp_d = 1'b0;
      sv_en       = 1'b0;
      ld_sel      = 1'b1;
      ers_sel_d   = '0;
      arr_pgm_stb = 1'b0;
      arr_ers_stb = 1'b0;
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      from_susp  <= 1'b0;
      sv_st      <= S_IDLE;
      sv_cnt     <= '0;
      pgm_addr_q <= '0;
      pgm_mask_q <= '0;
      tgt7_q     <= 1'b0;
      ers_sel    <= '0;
      ers_sect   <= '0;
      ers_byte   <= '0;
    end else begin
      st        <= st_d;
      cnt       <= cnt_d;
      from_susp <= from_susp_d;
      if (sv_en) begin
        sv_st  <= st;
        sv_cnt <= cnt;
      end
      if (ld_pgm) begin
        pgm_addr_q <= cmd_addr;
        pgm_mask_q <= ~cmd_data;
      end
      if (ld_tgt) tgt7_q  <= tgt7_d;
      if (ld_sel) ers_sel <= ers_sel_d;
      if (pos_we) begin
        ers_sect <= ers_sect_d;
        ers_byte <= ers_byte_d;
      end
    end
  end

  fos_cell_array #(.N_SECT(N_SECT), .SECT_BYTES(SECT_BYTES)) u_arr (
    .clk      (clk),
    .rst_n    (rst_n),
    .pgm_stb  (arr_pgm_stb),
    .pgm_addr (arr_addr),
    .pgm_mask (arr_mask),
    .ers_stb  (arr_ers_stb),
    .ers_sect (ers_sect),
    .rd_addr  (rd_addr),
    .rd_byte  (rd_byte),
    .vfy_addr (arr_addr),
    .vfy_byte (vfy_byte),
    .sect_ff  (sect_ff)
  );

  fos_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .busy     (busy),
    .tgt7     (in_ers ? 1'b1 : tgt7_q),
    .arr_byte (rd_byte),
    .rd_data  (rd_data)
  );

  AST_ABORT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_rst_n |=> ry_by); // R10

  AST_LOWVCC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && low_vcc && hw_rst_n) |=> (st == S_IDLE)); // R11

  AST_SUSP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SUSP) |=> ($stable(ers_sect) && $stable(ers_byte))); // R8

  AST_PROT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PROT_WAIT) |-> (!arr_pgm_stb && !arr_ers_stb)); // R5

  AST_PGM_IGNORES_CMDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PGM_PULSE && hw_rst_n && cnt != CW'(PGM_PULSE - 1)) |=> (st == S_PGM_PULSE)); // R12

endmodule

// File: tb/sim_flash_op_seq.sv
module sim_flash_op_seq;
  localparam int NS = 32, SB = 4, PP = 3, EP = 5, PC = 4;
  localparam int NB = NS * SB;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, hw_rst_n, low_vcc, cmd_valid, rd_en;
  logic [7:0]  protect, cmd_data, rd_data;
  logic [2:0]  cmd_op;
  logic [6:0]  cmd_addr, rd_addr;
  logic [31:0] cmd_sect_mask;
  logic        ry_by;

  flash_op_seq u0 (
    .clk(clk), .rst_n(rst_n), .hw_rst_n(hw_rst_n), .low_vcc(low_vcc),
    .protect(protect), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_sect_mask(cmd_sect_mask),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .ry_by(ry_by)
  );

  // behavioural reference state
  logic [7:0]  marr [NB];
  logic [31:0] m_esel;
  int          m_prem, m_erem;
  bit          m_pact, m_eact, m_susp, m_prot, m_tgt7, m_tog;
  int          m_paddr;
  logic [7:0]  m_pdata;
  int          n_vec = 0, n_bad = 0;
  string       cur_req = "R1";

  function automatic bit prot_of(int s);
    return protect[s / 4];
  endfunction

  function automatic int cost_erase(logic [31:0] sel);
    int c = 0;
    for (int s = 0; s < NS; s++)
      if (sel[s]) begin
        c += SB + 1 + 8 * (EP + 1);
        for (int b = 0; b < SB; b++) c += $countones(marr[s * SB + b]) * (PP + 1);
      end
    return c;
  endfunction

  task automatic launch_prog();
    m_pact  = 1;
    m_paddr = int'(cmd_addr);
    m_pdata = cmd_data;
    m_tgt7  = cmd_data[7];
    m_prot  = prot_of(m_paddr / SB);
    m_prem  = m_prot ? PC : 1 + $countones(marr[m_paddr] & ~cmd_data) * (PP + 1);
  endtask

  task automatic tick();
    bit         busy_pre, rd_chk, exp_ry;
    logic [7:0] exp_rd;
    logic [31:0] eff;
    @(posedge clk);
    busy_pre = m_pact || (m_eact && !m_susp);
    rd_chk   = rd_en;
    exp_rd   = 8'h00;
    if (rd_en) begin
      if (busy_pre) begin
        exp_rd = {~(m_pact ? m_tgt7 : 1'b1), m_tog, 6'b0};
        m_tog  = ~m_tog;
      end else begin
        exp_rd = marr[rd_addr];
      end
    end
    if (!hw_rst_n) begin
      m_pact = 0; m_eact = 0; m_susp = 0;
    end else if (m_pact) begin
      m_prem--;
      if (m_prem == 0) begin
        m_pact = 0;
        if (!m_prot) marr[m_paddr] = marr[m_paddr] & m_pdata;
      end
    end else if (m_eact && !m_susp) begin
      if (cmd_valid && cmd_op == 3'd3) m_susp = 1;
      else begin
        m_erem--;
        if (m_erem == 0) begin
          m_eact = 0;
          for (int i = 0; i < NB; i++) if (m_esel[i / SB]) marr[i] = 8'hFF;
        end
      end
    end else if (m_eact && m_susp) begin
      if (cmd_valid && cmd_op == 3'd4) m_susp = 0;
      else if (cmd_valid && !low_vcc && cmd_op == 3'd1 && !m_esel[cmd_addr / SB]) launch_prog();
    end else if (cmd_valid && !low_vcc) begin
      if (cmd_op == 3'd1) launch_prog();
      else if (cmd_op == 3'd2 && cmd_sect_mask != 0) begin
        eff = cmd_sect_mask;
        for (int s = 0; s < NS; s++) if (prot_of(s)) eff[s] = 1'b0;
        if (eff == 0) begin
          m_pact = 1; m_prot = 1; m_tgt7 = 1; m_prem = PC;
        end else begin
          m_eact = 1; m_esel = eff; m_erem = cost_erase(eff);
        end
      end
    end
    #2;
    exp_ry = !(m_pact || (m_eact && !m_susp));
    n_vec++;
    if (ry_by !== exp_ry) begin
      n_bad++;
      $display("FAIL %s ry_by act=%0b exp=%0b t=%0t", cur_req, ry_by, exp_ry, $time);
    end
    if (rd_chk) begin
      n_vec++;
      if (rd_data !== exp_rd) begin
        n_bad++;
        $display("FAIL %s rd_data act=%02h exp=%02h t=%0t", cur_req, rd_data, exp_rd, $time);
      end
    end
  endtask

  task automatic cmd(input logic [2:0] o, input int a, input logic [7:0] d, input logic [31:0] m);
    cmd_valid = 1; cmd_op = o; cmd_addr = 7'(a); cmd_data = d; cmd_sect_mask = m;
    tick();
    cmd_valid = 0; cmd_op = 3'd0;
  endtask

  task automatic rd(input int a);
    rd_en = 1; rd_addr = 7'(a);
    tick();
    rd_en = 0;
  endtask

  task automatic idle_wait();
    for (int i = 0; i < 5000 && (m_pact || (m_eact && !m_susp)); i++) tick();
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
  end

  initial begin
    rst_n = 0; hw_rst_n = 1; low_vcc = 0; protect = 8'h00; cmd_valid = 0;
    cmd_op = 3'd0; cmd_addr = '0; cmd_data = '0; cmd_sect_mask = '0; rd_en = 0; rd_addr = '0;
    for (int i = 0; i < NB; i++) marr[i] = 8'hFF;
    m_esel = '0; m_prem = 0; m_erem = 0; m_pact = 0; m_eact = 0; m_susp = 0;
    m_prot = 0; m_tgt7 = 0; m_tog = 0; m_paddr = 0; m_pdata = '0;
    repeat (3) @(posedge clk);
    #3 rst_n = 1;

    // R1: reset state
    cur_req = "R1";
    rd(0); rd(63); rd(127);

    // R2: program timing and value; R6: status reads in flight
    cur_req = "R2";
    cmd(3'd1, 2, 8'hA5, '0);
    cur_req = "R6";
    rd(2); rd(2); rd(2);
    cur_req = "R2";
    idle_wait(); rd(2);
    cmd(3'd1, 2, 8'h0F, '0); idle_wait(); rd(2);
    cmd(3'd1, 2, 8'hFF, '0); idle_wait(); rd(2);

    // R12: erase request during a program is ignored
    cur_req = "R12";
    cmd(3'd1, 5, 8'h3C, '0);
    cmd(3'd2, 0, 8'h00, 32'h0000_0002);
    cmd(3'd3, 0, 8'h00, '0);
    idle_wait(); rd(5);

    // R3: single sector erase with preprogram
    cur_req = "R3";
    cmd(3'd2, 0, 8'h00, 32'h0000_0001);
    rd(0); rd(0);
    idle_wait(); rd(2); rd(0);

    // R4: multi-sector erase, other sector kept
    cur_req = "R4";
    cmd(3'd1, 9, 8'h12, '0);  idle_wait();
    cmd(3'd1, 14, 8'h80, '0); idle_wait();
    cmd(3'd2, 0, 8'h00, 32'h0000_000C); idle_wait();
    rd(9); rd(14); rd(5);
    cmd(3'd2, 0, 8'h00, 32'h0); tick(); rd(5);

    // R5: protection
    cur_req = "R5";
    cmd(3'd1, 17, 8'h55, '0); idle_wait();
    cmd(3'd1, 33, 8'h66, '0); idle_wait();
    protect = 8'h02;
    cmd(3'd1, 21, 8'h00, '0); idle_wait(); rd(21);
    cmd(3'd2, 0, 8'h00, 32'h0000_0010); idle_wait(); rd(17);
    cmd(3'd2, 0, 8'h00, 32'h0000_0110); idle_wait(); rd(17); rd(33);
    protect = 8'h00;

    // R11: low supply blocks writes
    cur_req = "R11";
    low_vcc = 1;
    cmd(3'd1, 40, 8'h00, '0); tick(); rd(40);
    cmd(3'd2, 0, 8'h00, 32'h0000_0010); tick(); rd(17);
    low_vcc = 0;

    // R8 / R9: suspend, program around the erase, resume
    cur_req = "R8";
    cmd(3'd1, 41, 8'h0F, '0); idle_wait();
    cmd(3'd2, 0, 8'h00, 32'h0000_0400);
    repeat (20) tick();
    cmd(3'd3, 0, 8'h00, '0);
    tick(); rd(2);
    cur_req = "R9";
    cmd(3'd1, 49, 8'hC3, '0); rd(49); idle_wait(); rd(49);
    cmd(3'd1, 42, 8'h00, '0); tick(); rd(49);
    cmd(3'd2, 0, 8'h00, 32'h0001_0000); tick();
    cur_req = "R8";
    cmd(3'd4, 0, 8'h00, '0);
    idle_wait(); rd(41); rd(42);
    cur_req = "R7";
    rd(49); rd(64);

    // R10: abort mid-erase
    cur_req = "R10";
    cmd(3'd1, 53, 8'h5A, '0); idle_wait();
    cmd(3'd2, 0, 8'h00, 32'h0000_1000);
    repeat (10) tick();
    hw_rst_n = 0; tick(); hw_rst_n = 1;
    rd(53);
    cmd(3'd1, 53, 8'h0A, '0); idle_wait(); rd(53);

    summary();
  end
endmodule